// File: doc/BRIEF.md
# Systolic Column SAD Engine

This engine scores one four-pixel vertical column of the current block against a stream of reference pixels, one vertical candidate after another. Four chained stages each hold one current pixel. Each stage does a single three-operand step: it takes the absolute difference between its held pixel and the incoming reference pixel and adds the partial sum handed down by the stage above. The last stage's register is the finished sum of absolute differences (SAD) for one candidate.

Every accepted reference pixel is broadcast to all four stages at once. Stage i is i cycles behind stage 0 in the candidate it works on, so each stage meets the reference row it needs in the same cycle that row arrives. Vertically adjacent candidates share three of their four rows. Because of that, each new candidate costs one new reference pixel, and no reference pixel is fetched twice. A start pulse loads the current column and clears the pipeline. A gap in the reference stream freezes everything in place.

Top module: `col_sad_systolic`

## Requirements
- R1: While reset is held and right after it, `sad_valid` is 0 and `sad` is 0.
- R2: A `start` cycle loads the current column, with row i taken from `cur_col` bits [8i+7:8i]. It clears all partial sums and `sad` to 0, drops `sad_valid` for the next cycle, and discards the reference pixel offered in that cycle even when `ref_valid` is 1.
- R3: Number the reference pixels accepted since the last start from 0. The result for candidate k is the sum over i = 0..3 of |row i of the current column − reference pixel k+i|.
- R4: The first result has `sad_valid` high in the cycle after the fourth accepted pixel. No result is flagged before that.
- R5: After the fourth accepted pixel, every further accepted pixel yields exactly one more result in the following cycle. So n candidates need n+3 reference pixels, and with an unbroken stream they complete 5+(n−1) cycles after the start cycle begins.
- R6: In a cycle with `ref_valid` low and no start, `sad_valid` goes low in the next cycle and `sad` keeps its value. The pixel on `ref_pix` is ignored, and later results are the same as if the gap had not occurred.
- R7: The loaded current column is held for the whole search. `cur_col` has no effect outside a start cycle.
- R8: `sad` is 10 bits wide and reaches its maximum of 1020 without wrapping, for both signs of the pixel difference.
- R9: A start in the middle of a stream discards every candidate in flight. Four new pixels are needed before the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load current column and clear the pipeline |
| cur_col | input | 32 | Current column, row i in bits [8i+7:8i] |
| ref_valid | input | 1 | Reference pixel on `ref_pix` is offered this cycle |
| ref_pix | input | 8 | Next reference row pixel, unsigned |
| sad_valid | output | 1 | `sad` carries a newly completed candidate |
| sad | output | 10 | Sum of absolute differences of the last stage |

## Verification
A wrong held current pixel corrupts every result from the first one onward, and the error is always in the same row term. A miscounted fill shows up at once as `sad_valid` arriving one pixel early or late after a start. A stage that keeps advancing through a stall gives the wrong value for the first result after the gap. A stale partial sum left behind by a restart spoils the first result after the fourth new pixel. In every case the fault reaches the ports within four accepted pixels of its cause.

// File: rtl/col_sad_pkg.sv
package col_sad_pkg;

    localparam int PIX_W_DEF = 8;
    localparam int ROWS_DEF  = 4;

    // Per-cycle control shared by every stage of the chain
    typedef struct packed {
        logic clr;   // wipe partial sums
        logic adv;   // consume the broadcast reference pixel
    } stage_ctl_t;

    // Width that holds ROWS maximal absolute differences
    function automatic int sad_bits(input int pix_w, input int rows);
        return pix_w + $clog2(rows);
    endfunction

    function automatic int sad_peak(input int pix_w, input int rows);
        return rows * ((1 << pix_w) - 1);
    endfunction

endpackage

// File: rtl/col_sad_stage.sv
module col_sad_stage
    import col_sad_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int SAD_W = sad_bits(PIX_W_DEF, ROWS_DEF),
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_ctl_t       ctl,
    input  logic             load_cur,
    input  logic [PIX_W-1:0] cur_pix,
    input  logic [PIX_W-1:0] ref_pix,
    input  logic [SAD_W-1:0] part_in,
    output logic [SAD_W-1:0] part_out
);

    localparam int PART_MAX = sad_peak(PIX_W, IDX + 1);

    logic [PIX_W-1:0] cur_q;
    logic [SAD_W-1:0] part_q;
    logic [SAD_W-1:0] absd;

    always_comb begin
        if (cur_q > ref_pix) absd = SAD_W'(cur_q - ref_pix);
        else                 absd = SAD_W'(ref_pix - cur_q);
    end

    always_ff @(posedge clk) begin
        if (rst)           cur_q <= '0;
        else if (load_cur) cur_q <= cur_pix;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) part_q <= '0;
        else if (ctl.adv)   part_q <= part_in + absd;
    end

    assign part_out = part_q;

    // R8: a stage never holds more than IDX+1 worst-case differences
    assert_part_bound_R8: assert property (@(posedge clk) disable iff (rst)
        part_q <= SAD_W'(PART_MAX));

    // R6: without advance or clear the partial sum is frozen
    assert_part_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctl.adv && !ctl.clr) |=> $stable(part_q));

endmodule

// File: rtl/col_sad_fill.sv
module col_sad_fill
    import col_sad_pkg::*;
#(
    parameter int ROWS = ROWS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       ref_valid,
    output stage_ctl_t ctl,
    output logic       out_valid
);

    localparam int CW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CW-1:0] PRIMED = CW'(ROWS - 1);

    logic [CW-1:0] fill_q;
    logic          vld_q;

    always_comb begin
        ctl.clr = start;
        ctl.adv = ref_valid && !start;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            fill_q <= '0;
        end else if (ref_valid && fill_q != PRIMED) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= ref_valid && !start && (fill_q == PRIMED);
    end

    assign out_valid = vld_q;

    // R9: a restart suppresses any result in the following cycle
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> !out_valid);

    // R4: fill counter only moves on accepted pixels or restart
    assert_fill_move_R4: assert property (@(posedge clk) disable iff (rst)
        (!ref_valid && !start) |=> $stable(fill_q));

endmodule

// File: rtl/col_sad_systolic.sv
module col_sad_systolic
    import col_sad_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int ROWS  = ROWS_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ROWS*PIX_W-1:0]         cur_col,
    input  logic                          ref_valid,
    input  logic [PIX_W-1:0]              ref_pix,
    output logic                          sad_valid,
    output logic [sad_bits(PIX_W,ROWS)-1:0] sad
);

    localparam int SAD_W   = sad_bits(PIX_W, ROWS);
    localparam int SAD_TOP = sad_peak(PIX_W, ROWS);

    stage_ctl_t       ctl;
    logic [SAD_W-1:0] chain [ROWS+1];

    assign chain[0] = '0;

    col_sad_fill #(.ROWS(ROWS)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ref_valid (ref_valid),
        .ctl       (ctl),
        .out_valid (sad_valid)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_stage
        col_sad_stage #(
            .PIX_W (PIX_W),
            .SAD_W (SAD_W),
            .IDX   (g)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .load_cur (start),
            .cur_pix  (cur_col[g*PIX_W +: PIX_W]),
            .ref_pix  (ref_pix),
            .part_in  (chain[g]),
            .part_out (chain[g+1])
        );
    end

    assign sad = chain[ROWS];

    // R6: a gap yields no result and freezes the output
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!ref_valid && !start) |=> (!sad_valid && $stable(sad)));

    // R5: each flagged result comes from a pixel accepted one cycle earlier
    assert_valid_src_R5: assert property (@(posedge clk) disable iff (rst)
        sad_valid |-> $past(ref_valid && !start));

    // R8: output stays inside the representable range
    assert_sad_range_R8: assert property (@(posedge clk) disable iff (rst)
        sad <= SAD_W'(SAD_TOP));

    // R2: a start cycle leaves the output cleared
    assert_start_clear_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (sad == '0));

endmodule

// File: tb/sim_col_sad_systolic.sv
module sim_col_sad_systolic;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cur_col = '0;
    logic        ref_valid = 1'b0;
    logic [7:0]  ref_pix = '0;
    logic        sad_valid;
    logic [9:0]  sad;

    always #2.5 clk = ~clk;

    col_sad_systolic u0 (
        .clk(clk), .rst(rst), .start(start), .cur_col(cur_col),
        .ref_valid(ref_valid), .ref_pix(ref_pix),
        .sad_valid(sad_valid), .sad(sad)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    logic [7:0]  m_cur [4];
    logic [7:0]  m_hist [4];
    int          m_acc = 0;
    logic [9:0]  m_last = '0;
    logic [15:0] lfsr = 16'hACE1;
    int          n_vld = 0;

    function automatic logic [7:0] rnd8();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0] ^ lfsr[15:8];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check at the next falling edge
    task automatic step(input bit st, input bit v, input logic [7:0] px,
                        input logic [31:0] col, input string req);
        int e;
        start = st; ref_valid = v; ref_pix = px; cur_col = col;
        @(negedge clk);
        if (st) begin
            for (int i = 0; i < 4; i++) m_cur[i] = col[8*i +: 8];
            m_acc = 0;
            chk({req, " start valid"}, int'(sad_valid), 0);
            chk({req, " start clear"}, int'(sad), 0);
        end else if (v) begin
            for (int i = 0; i < 3; i++) m_hist[i] = m_hist[i+1];
            m_hist[3] = px;
            m_acc++;
            if (m_acc >= 4) begin
                e = 0;
                for (int i = 0; i < 4; i++)
                    e += (m_cur[i] > m_hist[i]) ? int'(m_cur[i] - m_hist[i])
                                                : int'(m_hist[i] - m_cur[i]);
                chk({req, " valid"}, int'(sad_valid), 1);
                chk({req, " sad"}, int'(sad), e);
                n_vld++;
            end else begin
                chk({req, " fill valid"}, int'(sad_valid), 0);
            end
        end else begin
            chk({req, " stall valid"}, int'(sad_valid), 0);
            chk({req, " stall hold"}, int'(sad), int'(m_last));
        end
        m_last = sad;
    endtask

    task automatic idle();
        start = 0; ref_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 valid", int'(sad_valid), 0);
        chk("R1 sad", int'(sad), 0);
        m_last = sad;
    endtask

    task automatic t_basic();
        int cyc = 0;
        int last = 0;
        step(1, 0, 8'h00, 32'h40_80_10_C8, "R2");
        cyc = 1;
        n_vld = 0;
        for (int k = 0; k < 12; k++) begin
            step(0, 1, rnd8(), {rnd8(), rnd8(), rnd8(), rnd8()}, "R3");
            cyc++;
            if (sad_valid) last = cyc;
        end
        chk("R5 result count", n_vld, 9);
        chk("R5 cycles to ninth result", last, 5 + (9 - 1));
        idle();
    endtask

    task automatic t_stall();
        step(1, 0, 8'h00, 32'h05_F0_7A_33, "R2");
        for (int k = 0; k < 24; k++)
            step(0, (k % 3) != 1, rnd8(), {rnd8(), rnd8(), rnd8(), rnd8()}, "R6");
        idle();
    endtask

    task automatic t_hold();
        step(1, 0, 8'h00, 32'h9C_21_E7_6B, "R2");
        for (int k = 0; k < 30; k++)
            step(0, 1, rnd8(), {rnd8(), rnd8(), rnd8(), rnd8()}, "R7");
        idle();
    endtask

    task automatic t_extreme();
        step(1, 0, 8'h00, 32'h00_00_00_00, "R2");
        for (int k = 0; k < 6; k++) step(0, 1, 8'hFF, 32'h0, "R8");
        chk("R8 max low cur", int'(sad), 1020);
        step(1, 0, 8'h00, 32'hFF_FF_FF_FF, "R2");
        for (int k = 0; k < 6; k++) step(0, 1, 8'h00, 32'h0, "R8");
        chk("R8 max high cur", int'(sad), 1020);
        idle();
    endtask

    task automatic t_restart();
        step(1, 0, 8'h00, 32'h11_22_33_44, "R2");
        for (int k = 0; k < 6; k++) step(0, 1, rnd8(), 32'h0, "R9");
        // start with a valid pixel offered: pixel must be dropped
        step(1, 1, 8'hEE, 32'h80_7F_01_FE, "R2");
        for (int k = 0; k < 3; k++) begin
            step(0, 1, rnd8(), 32'h0, "R9");
            chk("R9 no early result", int'(sad_valid), 0);
        end
        step(0, 1, rnd8(), 32'h0, "R9");
        chk("R9 first after restart", int'(sad_valid), 1);
        for (int k = 0; k < 5; k++) step(0, 1, rnd8(), 32'h0, "R4");
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_hold();
        t_extreme();
        t_restart();
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule